// File: doc/BRIEF.md
# High-Speed Clock Setup Register Unit

This unit holds the software-visible settings that bring up a microcontroller's high-speed system clock. Three small registers sit on a simple write/read bus. The first register holds a frequency-range bit. The second holds two pin-mode bits, which place the two clock pins in general I/O use, in crystal oscillation or in external clock input. The third holds a stop bit that gates the external clock input. Software is expected to program them in this order: range first, then pin mode, then clear the stop bit.

The range bit is write-once. The first write after reset is stored and uses up the permission, whatever value it carries, and every later write is dropped. When that first write stores a 1, the unit withholds the CPU clock enable for a fixed number of external clock cycles. The stall counter runs on the external clock. Its completion flag returns to the bus clock through a flop synchronizer, and software can poll a busy bit to see when the stall is over. While the external clock input is enabled (stop bit 0), the pin-mode bits are locked.

Top module: `osc_ctrl_unit`

## Requirements
- R1: After reset the range bit reads 0, both pin-mode bits read 0 (port mode), the stop bit reads 1, the busy bit reads 0, `cpu_clk_en` is 1 and `ext_in_en` is 0.
- R2: Register 0 bit 0 is the range bit: 0 selects the 1 to 10 MHz band and 1 selects above 10 MHz up to 20 MHz. The first write to register 0 after reset stores bit 0 of the write data.
- R3: Every write to register 0 after the first one since reset leaves the range bit unchanged, including when the first write carried a 0.
- R4: When the first write stores a 1 in the range bit, `cpu_clk_en` goes low once and stays low for exactly `STALL_CYCLES` (default 160) consecutive `ext_clk` rising edges. It then returns to 1 and stays at 1 until the next reset.
- R5: When the first write stores a 0 in the range bit, no stall occurs: `cpu_clk_en` stays 1 and the busy bit stays 0.
- R6: Register 0 bit `DATA_W-1` is a read-only busy bit. It reads 1 from the cycle after an accepted write of 1 to the range bit until the synchronized stall completion arrives. Once the stall has ended it reads 0.
- R7: Register 1 bit 0 selects oscillator pins and bit 1 selects external input. `pin_mode` is 0 (port) when bit 0 is 0, 1 (crystal) when bit 0 is 1 and bit 1 is 0, and 2 (external clock) when both are 1.
- R8: Writes to register 1 are ignored while the stop bit is 0.
- R9: Register 2 bit 0 is the stop bit, and `ext_in_en` is its inverse: clearing it enables the external clock input and setting it disables that input.
- R10: Unused bits of registers 0 to 2 read 0. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ext_clk | input | 1 | External high-speed clock that times the stall |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| addr | input | ADDR_W | Register address for writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register (combinational) |
| pin_mode | output | 2 | Clock pin function: 0 port, 1 crystal, 2 external clock |
| ext_in_en | output | 1 | External clock input enable |
| cpu_clk_en | output | 1 | CPU clock enable, low during the stall (`ext_clk` domain) |

## Verification
The stall completion and a rejected range write can fall in the same bus cycle. This happens when the synchronized done flag clears the busy bit at the same edge where software retries a write to register 0. To provoke it, the bench keeps writing register 0 for the whole length of the stall, so that one of those writes lands on the cycle in which busy falls. The bench judges the result by comparing the range bit against its reference model on every clock. It also counts the low cycles of `cpu_clk_en` on the external clock, which must total exactly 160 with a single falling edge, and it checks that busy reads 0 a few cycles after the stall ends.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

    typedef enum logic [1:0] {
        PINS_PORT    = 2'd0,
        PINS_CRYSTAL = 2'd1,
        PINS_EXTCLK  = 2'd2
    } pin_mode_e;

    localparam int unsigned REG_FREQ = 0;
    localparam int unsigned REG_PINS = 1;
    localparam int unsigned REG_STOP = 2;

    typedef struct packed {
        logic range_hi;
        logic range_used;
        logic osc_sel;
        logic ext_sel;
        logic stop;
        logic stall_req;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        range_hi:   1'b0,
        range_used: 1'b0,
        osc_sel:    1'b0,
        ext_sel:    1'b0,
        stop:       1'b1,
        stall_req:  1'b0
    };

endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    assign chain_d[0] = din;
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        assign chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/osc_reg_file.sv
module osc_reg_file
    import osc_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stall_done,
    output logic [DATA_W-1:0] rdata,
    output logic              range_hi,
    output logic              range_used,
    output logic              osc_sel,
    output logic              ext_sel,
    output logic              stop,
    output logic              stall_req,
    output logic              busy
);
    localparam int unsigned         BUSY_POS = DATA_W - 1;
    localparam logic [ADDR_W-1:0]   A_FREQ   = ADDR_W'(REG_FREQ);
    localparam logic [ADDR_W-1:0]   A_PINS   = ADDR_W'(REG_PINS);
    localparam logic [ADDR_W-1:0]   A_STOP   = ADDR_W'(REG_STOP);

    cfg_t state_d;
    cfg_t state_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:2];

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (addr == A_FREQ) begin
                if (!state_q.range_used) begin
                    state_d.range_used = 1'b1;
                    state_d.range_hi   = wdata[0];
                    state_d.stall_req  = wdata[0];
                end
            end else if (addr == A_PINS) begin
                if (state_q.stop) begin
                    state_d.osc_sel = wdata[0];
                    state_d.ext_sel = wdata[1];
                end
            end else if (addr == A_STOP) begin
                state_d.stop = wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_RESET;
        else        state_q <= state_d;
    end

    assign busy = state_q.stall_req & ~stall_done;

    always_comb begin
        rdata = '0;
        if (addr == A_FREQ) begin
            rdata[0]        = state_q.range_hi;
            rdata[BUSY_POS] = busy;
        end else if (addr == A_PINS) begin
            rdata[0] = state_q.osc_sel;
            rdata[1] = state_q.ext_sel;
        end else if (addr == A_STOP) begin
            rdata[0] = state_q.stop;
        end
    end

    assign range_hi   = state_q.range_hi;
    assign range_used = state_q.range_used;
    assign osc_sel    = state_q.osc_sel;
    assign ext_sel    = state_q.ext_sel;
    assign stop       = state_q.stop;
    assign stall_req  = state_q.stall_req;
endmodule

// File: rtl/osc_stall_timer.sv
module osc_stall_timer #(
    parameter int unsigned CYCLES      = 160,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic ext_clk,
    input  logic rst_n,
    input  logic start_req,
    output logic cpu_clk_en,
    output logic done
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic             running;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d;
    tmr_t tmr_q;
    logic req_s;

    osc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (ext_clk),
        .rst_n (rst_n),
        .din   (start_req),
        .dout  (req_s)
    );

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.running) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.running = 1'b0;
                tmr_d.done    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (req_s && !tmr_q.done) begin
            tmr_d.running = 1'b1;
            tmr_d.cnt     = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge ext_clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{running: 1'b0, done: 1'b0, cnt: '0};
        else        tmr_q <= tmr_d;
    end

    assign cpu_clk_en = ~tmr_q.running;
    assign done       = tmr_q.done;
endmodule

// File: rtl/osc_ctrl_unit.sv
module osc_ctrl_unit
    import osc_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 2,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned STALL_CYCLES = 160,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        pin_mode,
    output logic              ext_in_en,
    output logic              cpu_clk_en
);
    logic range_hi_w;
    logic range_used_w;
    logic osc_sel_w;
    logic ext_sel_w;
    logic stop_w;
    logic stall_req_w;
    logic busy_w;
    logic done_ext_w;
    logic done_sync_w;
    pin_mode_e mode_w;

    osc_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .stall_done (done_sync_w),
        .rdata      (rdata),
        .range_hi   (range_hi_w),
        .range_used (range_used_w),
        .osc_sel    (osc_sel_w),
        .ext_sel    (ext_sel_w),
        .stop       (stop_w),
        .stall_req  (stall_req_w),
        .busy       (busy_w)
    );

    osc_stall_timer #(.CYCLES(STALL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
        .ext_clk    (ext_clk),
        .rst_n      (rst_n),
        .start_req  (stall_req_w),
        .cpu_clk_en (cpu_clk_en),
        .done       (done_ext_w)
    );

    osc_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (done_ext_w),
        .dout  (done_sync_w)
    );

    always_comb begin
        if (!osc_sel_w)     mode_w = PINS_PORT;
        else if (!ext_sel_w) mode_w = PINS_CRYSTAL;
        else                mode_w = PINS_EXTCLK;
    end

    assign pin_mode  = mode_w;
    assign ext_in_en = ~stop_w;
endmodule

// File: rtl/osc_ctrl_unit_chk.sv
module osc_ctrl_unit_chk
    import osc_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 2,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned STALL_CYCLES = 160
) (
    input logic              clk,
    input logic              ext_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              range_hi,
    input logic              range_used,
    input logic              stop,
    input logic              busy,
    input logic [1:0]        pin_mode,
    input logic              ext_in_en,
    input logic              cpu_clk_en
);
    localparam int unsigned       LOW_W  = $clog2(STALL_CYCLES + 1) + 2;
    localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(REG_FREQ);
    localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(REG_PINS);
    localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(REG_STOP);

    logic [LOW_W-1:0] low_cnt_q;
    logic             unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:2];

    always_ff @(posedge ext_clk or negedge rst_n) begin
        if (!rst_n)          low_cnt_q <= '0;
        else if (!cpu_clk_en) low_cnt_q <= low_cnt_q + 1'b1;
    end

    // R3: once the permission is used, the range bit does not move on a write
    p_range_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FREQ && range_used) |=> (range_hi == $past(range_hi)));

    // R4: the CPU clock is never held off for more than the stall length
    p_stall_len_r4: assert property (@(posedge ext_clk) disable iff (!rst_n)
        (low_cnt_q <= LOW_W'(STALL_CYCLES)));

    // R5: without a stored range of 1 the CPU clock stays enabled
    p_no_stall_r5: assert property (@(posedge ext_clk) disable iff (!rst_n)
        (!range_hi) |-> cpu_clk_en);

    // R6: an accepted write of 1 raises busy on the next cycle
    p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FREQ && !range_used && wdata[0]) |=> busy);

    // R7: both select bits written while unlocked give external clock mode
    p_mode_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PINS && stop && wdata[1:0] == 2'b11) |=> (pin_mode == PINS_EXTCLK));

    // R8: pin mode cannot change while the external input is enabled
    p_pins_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PINS && !stop) |=> $stable(pin_mode));

    // R9: the input enable follows the written stop value
    p_stop_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STOP) |=> (ext_in_en == !$past(wdata[0])));
endmodule

bind osc_ctrl_unit osc_ctrl_unit_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .STALL_CYCLES (STALL_CYCLES)
) u_chk (
    .clk        (clk),
    .ext_clk    (ext_clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .range_hi   (range_hi_w),
    .range_used (range_used_w),
    .stop       (stop_w),
    .busy       (busy_w),
    .pin_mode   (pin_mode),
    .ext_in_en  (ext_in_en),
    .cpu_clk_en (cpu_clk_en)
);

// File: tb/osc_ctrl_unit_tb.sv
module osc_ctrl_unit_tb;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int STALL  = 160;

    logic              clk;
    logic              ext_clk;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        pin_mode;
    logic              ext_in_en;
    logic              cpu_clk_en;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_range, m_used, m_osc, m_ext, m_stop;
    int low_cnt = 0;
    int falls = 0;
    bit prev_en = 1;

    osc_ctrl_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STALL_CYCLES(STALL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_mode(pin_mode), .ext_in_en(ext_in_en),
        .cpu_clk_en(cpu_clk_en)
    );

    initial clk = 0;
    always #4 clk = ~clk;
    initial begin
        ext_clk = 0;
        #3;
        forever #11 ext_clk = ~ext_clk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] model_read(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] v = '0;
        case (a)
            2'd0: v[0] = m_range;
            2'd1: begin v[0] = m_osc; v[1] = m_ext; end
            2'd2: v[0] = m_stop;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [1:0] model_mode();
        if (!m_osc) return 2'd0;
        if (!m_ext) return 2'd1;
        return 2'd2;
    endfunction

    // per-cycle comparison, then model update with inputs held until the next edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_range = 0; m_used = 0; m_osc = 0; m_ext = 0; m_stop = 1;
        end else if (cmp_en) begin
            logic [DATA_W-1:0] mask;
            mask = (addr == 2'd0) ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
            case (addr)
                2'd0: chk("R2 range readback", rdata & mask, model_read(addr));
                2'd1: chk("R7 pin readback", rdata, model_read(addr));
                2'd2: chk("R9 stop readback", rdata, model_read(addr));
                default: chk("R10 unmapped readback", rdata, model_read(addr));
            endcase
            chk("R7 pin_mode", pin_mode, model_mode());
            chk("R9 ext_in_en", ext_in_en, !m_stop);
            if (wr_en) begin
                case (addr)
                    2'd0: if (!m_used) begin m_used = 1; m_range = wdata[0]; end
                    2'd1: if (m_stop) begin m_osc = wdata[0]; m_ext = wdata[1]; end
                    2'd2: m_stop = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // stall monitor on the external clock
    always @(negedge ext_clk) begin
        if (!rst_n) prev_en = 1;
        else begin
            if (!cpu_clk_en) low_cnt++;
            if (prev_en && !cpu_clk_en) falls++;
            prev_en = cpu_clk_en;
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0; wr_en = 0; addr = 0; wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic check_reset_state();
        logic [DATA_W-1:0] v;
        rd(2'd0, v); chk("R1 reg0 after reset", v, 8'h00);
        rd(2'd1, v); chk("R1 reg1 after reset", v, 8'h00);
        rd(2'd2, v); chk("R1 reg2 after reset", v, 8'h01);
        chk("R1 cpu_clk_en after reset", cpu_clk_en, 1);
        chk("R1 ext_in_en after reset", ext_in_en, 0);
        chk("R1 pin_mode after reset", pin_mode, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        rst_n = 0; wr_en = 0; addr = 0; wdata = 0;
        do_reset();
        cmp_en = 1;
        check_reset_state();

        // R5 / R3: first write of 0 uses up the permission, no stall
        low_cnt = 0; falls = 0;
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd0, v);
        chk("R3 range stays 0 after late write", v[0], 0);
        chk("R5 busy stays 0", v[DATA_W-1], 0);
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk("R5 no stall cycles", low_cnt, 0);
        chk("R5 cpu_clk_en stays 1", cpu_clk_en, 1);

        // R10: unmapped address
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R10 addr3 reads 0", v, 0);
        rd(2'd2, v); chk("R10 stop unchanged by addr3 write", v, 8'h01);

        // R7: pin mode encodings
        wr(2'd1, 8'h01); @(negedge clk); chk("R7 crystal mode", pin_mode, 1);
        wr(2'd1, 8'h03); @(negedge clk); chk("R7 external mode", pin_mode, 2);
        wr(2'd1, 8'h02); @(negedge clk); chk("R7 ext bit alone is port", pin_mode, 0);
        wr(2'd1, 8'hFF); @(negedge clk); chk("R7 external mode again", pin_mode, 2);

        // R9 / R8: enable input, then pins locked
        wr(2'd2, 8'h00); @(negedge clk); chk("R9 input enabled", ext_in_en, 1);
        wr(2'd1, 8'h00); @(negedge clk); chk("R8 pins locked while running", pin_mode, 2);
        wr(2'd1, 8'h01); @(negedge clk); chk("R8 pins still locked", pin_mode, 2);

        // R1 again after non-default state
        do_reset();
        check_reset_state();

        // R4 / R6 / R3: stall, with range retries overlapping its end
        low_cnt = 0; falls = 0;
        wr(2'd0, 8'h01);
        rd(2'd0, v);
        chk("R6 busy set after accepted write", v[DATA_W-1], 1);
        chk("R2 range stored as 1", v[0], 1);
        for (int i = 0; i < 100 && cpu_clk_en; i++) @(posedge clk);
        @(negedge clk);
        chk("R4 cpu_clk_en low during stall", cpu_clk_en, 0);
        rd(2'd0, v);
        chk("R6 busy during stall", v[DATA_W-1], 1);
        for (int i = 0; i < 3000 && !cpu_clk_en; i++) wr(2'd0, 8'h00);
        for (int i = 0; i < 10; i++) wr(2'd0, 8'h00);
        rd(2'd0, v);
        chk("R6 busy clear after stall", v[DATA_W-1], 0);
        chk("R3 range kept across retries", v[0], 1);
        chk("R4 stall length", low_cnt, STALL);
        chk("R4 single stall window", falls, 1);
        repeat (400) @(posedge clk);
        @(negedge clk);
        chk("R4 no second stall", low_cnt, STALL);
        chk("R4 cpu_clk_en stays 1", cpu_clk_en, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule